// File: doc/BRIEF.md
# Multi-Die NOR Flash Bulk Erase Sequencer

This controller wipes every die of a stacked serial NOR flash over an SPI link while the part stays in 3-byte addressing. A 3-byte address only reaches half a die, so the die in use is picked through the extended-address register. That register steps by two for each die: 0, 2, 4, 6 for the default four dies. For every die the controller does four things in turn. It sets write-enable and loads the extended address. It sets write-enable again and issues the die-erase command. It then reads the status register until the write-in-progress bit clears. Last, it reads the flag status register to learn whether the die really finished.

A set bit 7 in the flag status moves the flow on to the next die. A clear bit 7 makes the controller erase the same die again. Two counters guard the flow. One limits the erase attempts per die and the other limits the status polls per erase. Either limit raises a sticky error and stops the run. A successful run ends with a one-cycle done pulse. Control and status pins are plain levels and pulses with no handshake. Inside the block, the flow engine and the SPI shifter pass one frame at a time over a request/acknowledge pair. A new request is raised only after the previous frame has been acknowledged.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, `spi_cs_n` is 1 and `spi_sck` is 0.
- R2: A `start` pulse is accepted only in a cycle where `busy` is 0. `busy` is 1 in the following cycle and `err` is cleared. A `start` seen while `busy` is 1 has no effect on the run. A `start` in the same cycle as `done` begins a new run.
- R3: SPI mode 0. `spi_sck` idles low and is low whenever `spi_cs_n` is high. Bits are sent MSB first. `spi_mosi` changes only while `spi_sck` is low. `spi_miso` is taken while `spi_sck` is high. `spi_cs_n` returns high between frames.
- R4: For die index d (counting from 0), the controller sends write-enable (8-bit frame 0x06) and then a 16-bit frame 0xC5 followed by the byte d*EXT_STEP. It then sends a second write-enable and a 32-bit frame of 0xC4 followed by three zero address bytes. Every 0xC5 and 0xC4 frame comes directly after its own 0x06 frame.
- R5: After each erase frame, the controller sends 16-bit frames of opcode 0x05 followed by 8 read bits. It keeps doing so while bit 0 of the returned byte is 1 and stops at the first read where bit 0 is 0.
- R6: After polling ends, the controller sends one 16-bit frame of opcode 0x70 followed by 8 read bits. If bit 7 is 1, it moves on to the next die, or finishes after the last die. If bit 7 is 0, it sends 0x06 and then 0xC4 again for the same die, without rewriting the extended address.
- R7: When MAX_RETRY flag reads for one die all return bit 7 = 0, `err` rises and the run stops with no further frames.
- R8: When MAX_POLLS status reads after one erase all return bit 0 = 1, `err` rises and the run stops.
- R9: `done` is high for exactly one cycle, right after the flag read of die NUM_DIES-1 returns bit 7 = 1. In that cycle `busy` and `err` are 0.
- R10: While `err` is 1, `busy` is 0. `err` stays 1 until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all logic on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a bulk erase run (pulse) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: all dies erased |
| err | output | 1 | Sticky: retry or poll limit reached |
| spi_sck | output | 1 | SPI serial clock, half the system rate |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
Two events can land in the same cycle: the end-of-run `done` pulse and a fresh `start`. The bench watches for `done` on the falling clock edge and raises `start` in that same cycle. It then expects `busy` one cycle later and a second complete run with its own `done`. A separate run pulses `start` in the middle of an erase and judges the result by the frame counts the flash model logs. Those counts must be identical to those of an undisturbed run.

// File: rtl/nes_pkg.sv
package nes_pkg;
  localparam int FRAME_W = 32;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_SETX  = 8'hC5;
  localparam logic [7:0] OP_ERASE = 8'hC4;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_RDFS  = 8'h70;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN_X,
    ST_SETX,
    ST_WREN_E,
    ST_ERASE,
    ST_POLL,
    ST_FLAG
  } step_t;
endpackage

// File: rtl/nes_spi_shift.sv
module nes_spi_shift #(
  parameter int FRAME_W = 32,
  parameter int CNT_W   = $clog2(FRAME_W + 9)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic [CNT_W-1:0]   tx_bits,
  input  logic [CNT_W-1:0]   rx_bits,
  output logic               ack,
  output logic               rx_msb,
  output logic               rx_lsb,
  output logic               sck,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  typedef enum logic [1:0] {SH_IDLE, SH_XFER, SH_HOLD, SH_GAP} sh_t;

  sh_t                st;
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   total;
  logic [CNT_W-1:0]   txn;
  logic [CNT_W-1:0]   idx;
  logic [7:0]         rx;

  assign mosi   = sreg[FRAME_W-1];
  assign rx_msb = rx[7];
  assign rx_lsb = rx[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SH_IDLE;
      sreg  <= '0;
      total <= '0;
      txn   <= '0;
      idx   <= '0;
      rx    <= '0;
      sck   <= 1'b0;
      cs_n  <= 1'b1;
      ack   <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (req) begin
            sreg  <= tx_word;
            total <= tx_bits + rx_bits;
            txn   <= tx_bits;
            idx   <= '0;
            cs_n  <= 1'b0;
            st    <= SH_XFER;
          end
        end
        SH_XFER: begin
          if (!sck) begin
            sck <= 1'b1;
          end else begin
            sck  <= 1'b0;
            sreg <= {sreg[FRAME_W-2:0], 1'b0};
            if (idx >= txn) rx <= {rx[6:0], miso};
            idx <= idx + 1'b1;
            if (idx == total - 1'b1) st <= SH_HOLD;
          end
        end
        SH_HOLD: begin
          cs_n <= 1'b1;
          st   <= SH_GAP;
        end
        default: begin
          ack <= 1'b1;
          st  <= SH_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/nes_flow.sv
module nes_flow
  import nes_pkg::*;
#(
  parameter int NUM_DIES  = 4,
  parameter int EXT_STEP  = 2,
  parameter int MAX_RETRY = 8,
  parameter int MAX_POLLS = 1000000,
  parameter int CNT_W     = $clog2(FRAME_W + 9)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               req,
  output logic [FRAME_W-1:0] tx_word,
  output logic [CNT_W-1:0]   tx_bits,
  output logic [CNT_W-1:0]   rx_bits,
  input  logic               ack,
  input  logic               rx_msb,
  input  logic               rx_lsb
);
  localparam int DIE_W  = (NUM_DIES > 1) ? $clog2(NUM_DIES) : 1;
  localparam int RTY_W  = $clog2(MAX_RETRY + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam logic [DIE_W-1:0]  LAST_DIE  = DIE_W'(NUM_DIES - 1);
  localparam logic [RTY_W-1:0]  LAST_TRY  = RTY_W'(MAX_RETRY - 1);
  localparam logic [POLL_W-1:0] LAST_POLL = POLL_W'(MAX_POLLS - 1);

  step_t             st;
  logic [DIE_W-1:0]  die;
  logic [RTY_W-1:0]  tries;
  logic [POLL_W-1:0] polls;
  logic              sent;
  logic [7:0]        ext;

  assign ext  = 8'(die) * 8'(EXT_STEP);
  assign busy = (st != ST_IDLE);
  assign req  = busy && !sent;

  always_comb begin
    tx_word = {OP_WREN, 24'h0};
    tx_bits = CNT_W'(8);
    rx_bits = '0;
    case (st)
      ST_SETX:  begin tx_word = {OP_SETX, ext, 16'h0}; tx_bits = CNT_W'(16); end
      ST_ERASE: begin tx_word = {OP_ERASE, 24'h0};     tx_bits = CNT_W'(32); end
      ST_POLL:  begin tx_word = {OP_RDSR, 24'h0};      rx_bits = CNT_W'(8);  end
      ST_FLAG:  begin tx_word = {OP_RDFS, 24'h0};      rx_bits = CNT_W'(8);  end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      die   <= '0;
      tries <= '0;
      polls <= '0;
      sent  <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (req) sent <= 1'b1;
      if (st == ST_IDLE) begin
        if (start) begin
          st    <= ST_WREN_X;
          die   <= '0;
          tries <= '0;
          err   <= 1'b0;
        end
      end else if (ack) begin
        sent <= 1'b0;
        case (st)
          ST_WREN_X: st <= ST_SETX;
          ST_SETX:   st <= ST_WREN_E;
          ST_WREN_E: st <= ST_ERASE;
          ST_ERASE: begin
            polls <= '0;
            st    <= ST_POLL;
          end
          ST_POLL: begin
            if (!rx_lsb) begin
              st <= ST_FLAG;
            end else if (polls == LAST_POLL) begin
              err <= 1'b1;
              st  <= ST_IDLE;
            end else begin
              polls <= polls + 1'b1;
            end
          end
          ST_FLAG: begin
            if (rx_msb) begin
              tries <= '0;
              if (die == LAST_DIE) begin
                done <= 1'b1;
                st   <= ST_IDLE;
              end else begin
                die <= die + 1'b1;
                st  <= ST_WREN_X;
              end
            end else if (tries == LAST_TRY) begin
              err <= 1'b1;
              st  <= ST_IDLE;
            end else begin
              tries <= tries + 1'b1;
              st    <= ST_WREN_E;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nes_pkg::*;
#(
  parameter int NUM_DIES  = 4,
  parameter int EXT_STEP  = 2,
  parameter int MAX_RETRY = 8,
  parameter int MAX_POLLS = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic err,
  output logic spi_sck,
  output logic spi_cs_n,
  output logic spi_mosi,
  input  logic spi_miso
);
  localparam int CNT_W = $clog2(FRAME_W + 9);

  logic               req;
  logic               ack;
  logic [FRAME_W-1:0] tx_word;
  logic [CNT_W-1:0]   tx_bits;
  logic [CNT_W-1:0]   rx_bits;
  logic               rx_msb;
  logic               rx_lsb;

  nes_flow #(
    .NUM_DIES (NUM_DIES),
    .EXT_STEP (EXT_STEP),
    .MAX_RETRY(MAX_RETRY),
    .MAX_POLLS(MAX_POLLS),
    .CNT_W    (CNT_W)
  ) u_flow (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .err    (err),
    .req    (req),
    .tx_word(tx_word),
    .tx_bits(tx_bits),
    .rx_bits(rx_bits),
    .ack    (ack),
    .rx_msb (rx_msb),
    .rx_lsb (rx_lsb)
  );

  nes_spi_shift #(
    .FRAME_W(FRAME_W),
    .CNT_W  (CNT_W)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .tx_word(tx_word),
    .tx_bits(tx_bits),
    .rx_bits(rx_bits),
    .ack    (ack),
    .rx_msb (rx_msb),
    .rx_lsb (rx_lsb),
    .sck    (spi_sck),
    .cs_n   (spi_cs_n),
    .mosi   (spi_mosi),
    .miso   (spi_miso)
  );
endmodule

// File: rtl/nes_checker.sv
module nes_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic spi_sck,
  input logic spi_cs_n,
  input logic spi_mosi
);
  // R3: clock parked low while deselected
  p_sck_parked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  // R3: data only moves during the low phase
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));
  // R2: no run begins without a start request
  p_start_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R2: the link is quiet outside a run
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);
  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: done only with the flow idle and clean
  p_done_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err));
  // R10: error holds until a new start
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> err);
  // R10: error only while stopped
  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
endmodule

bind nor_erase_seq nes_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .err     (err),
  .spi_sck (spi_sck),
  .spi_cs_n(spi_cs_n),
  .spi_mosi(spi_mosi)
);

// File: tb/sim_nor_erase_seq.sv
module sim_nor_erase_seq;
  localparam int CLK_PER = 10;
  localparam int NDIE    = 4;
  localparam int RTY     = 3;
  localparam int POLLS   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic miso = 1'b0;
  logic mdl_clr = 1'b0;
  wire  busy, done, err, sck, cs_n, mosi;

  always #(CLK_PER/2) clk = ~clk;

  nor_erase_seq #(
    .NUM_DIES(NDIE), .EXT_STEP(2), .MAX_RETRY(RTY), .MAX_POLLS(POLLS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err(err), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso)
  );

  // flash model
  logic [47:0] fr;
  logic [7:0]  op, b2;
  int nb, erase_n, wear_n, poll_n, viol, extbad, busy_left, cur_die;
  bit wel;
  int fused[NDIE];
  int B;
  int F[NDIE];

  always @(posedge sck or posedge cs_n or posedge mdl_clr) begin
    if (mdl_clr) begin
      nb = 0; erase_n = 0; wear_n = 0; poll_n = 0; viol = 0; extbad = 0;
      busy_left = 0; cur_die = 0; wel = 0; fr = '0; op = '0; b2 = '0;
      for (int i = 0; i < NDIE; i++) fused[i] = 0;
    end else if (cs_n) begin
      if (nb >= 8) begin
        case (op)
          8'h06: wel = 1;
          8'hC5: begin
            if (!wel || nb != 16) viol++;
            if (b2 != 8'(2 * (wear_n % NDIE))) extbad++;
            cur_die = (b2 / 2) % NDIE;
            wear_n++;
            wel = 0;
          end
          8'hC4: begin
            if (!wel || nb != 32) viol++;
            erase_n++;
            busy_left = B;
            wel = 0;
          end
          8'h05: begin
            poll_n++;
            if (busy_left > 0) busy_left--;
          end
          8'h70: if (fused[cur_die] < F[cur_die]) fused[cur_die]++;
          default: viol++;
        endcase
      end
      nb = 0;
    end else begin
      fr = {fr[46:0], mosi};
      nb++;
      if (nb == 8)  op = fr[7:0];
      if (nb == 16) b2 = fr[7:0];
    end
  end

  always @(negedge sck) begin
    logic [7:0] r;
    if (!cs_n && nb >= 8 && nb < 16) begin
      r = 8'h00;
      if (op == 8'h05) r = (busy_left > 0) ? 8'h03 : 8'h00;
      if (op == 8'h70) r = (fused[cur_die] < F[cur_die]) ? 8'h00 : 8'h80;
      miso <= r[15 - nb];
    end
  end

  int nvec = 0;
  int nbad = 0;

  task automatic chk(input string rq, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // wait for the run to end; watchdog counts as a failure
  task automatic wait_idle(input bit poke);
    int cyc = 0;
    while (busy && cyc < 30000) begin
      start = (poke && cyc == 50);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (cyc >= 30000) chk("watchdog", 1, 0);
  endtask

  task automatic run_case(input int b, input int f0, input int f1,
                          input int f2, input int f3, input bit poke,
                          input bit collide);
    int e_err, e_er, e_wr, e_pl;
    B = b; F[0] = f0; F[1] = f1; F[2] = f2; F[3] = f3;
    mdl_clr = 1'b1; #1; mdl_clr = 1'b0;
    e_err = 0; e_er = 0; e_wr = 0;
    if (b >= POLLS) begin
      e_err = 1; e_er = 1; e_wr = 1; e_pl = POLLS;
    end else begin
      for (int d = 0; d < NDIE; d++) begin
        e_wr++;
        if (F[d] >= RTY) begin e_er += RTY; e_err = 1; break; end
        e_er += F[d] + 1;
      end
      e_pl = e_er * (b + 1);
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R2 busy after start", busy, 1);
    chk("R10 err cleared by start", err, 0);
    wait_idle(poke);
    chk("R9 done at end", done, 1 - e_err);
    chk("R7/R8 err at end", err, e_err);
    chk("R4/R6/R7 erase frames", erase_n, e_er);
    chk("R4/R6 ext writes", wear_n, e_wr);
    chk("R5/R8 status polls", poll_n, e_pl);
    chk("R3/R4 protocol order", viol, 0);
    chk("R4 ext values", extbad, 0);
    if (collide && done) begin
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R2 start with done", busy, 1);
      wait_idle(1'b0);
      chk("R2 second run done", done, 1);
      chk("R2 second run erases", erase_n, 2 * NDIE);
    end else begin
      @(negedge clk);
      chk("R9 done single cycle", done, 0);
      chk("R10 err held", err, e_err);
    end
    chk("R10 idle at end", busy, 0);
  endtask

  int pats[6][NDIE] = '{'{0,0,0,0}, '{1,0,2,0}, '{2,2,2,2},
                        '{0,3,0,0}, '{3,0,0,0}, '{0,0,1,3}};

  initial begin
    mdl_clr = 1'b1; #1; mdl_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sck", sck, 0);
    for (int b = 0; b <= POLLS; b++)
      for (int p = 0; p < 6; p++)
        run_case(b, pats[p][0], pats[p][1], pats[p][2], pats[p][3], 1'b0, 1'b0);
    run_case(1, 1, 0, 1, 0, 1'b1, 1'b0);
    run_case(0, 0, 0, 0, 0, 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule